// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block holds two alarm settings and checks them against a running packed-BCD time and date. The time and date arrive as six fields: seconds, minutes, hours, date, month and day of week. Each alarm stores one byte per field. Bit 7 of a byte decides whether that field takes part in the comparison, and bits 6:0 hold the BCD value to match. A field that is switched off always counts as matching. Enabling only some fields therefore gives alarms that recur every minute, hour, day and so on.

The comparison runs only in the clock cycle in which the one-pulse-per-second tick is high. By then the time inputs already carry the new second. A hit sets a sticky per-alarm flag. The flag stays set until software writes a one to its bit of the status-clear register. An interrupt output is the OR of those flags whose interrupt enable is set.

A per-alarm mode bit chooses between two behaviours. In repeat mode the alarm can fire on every matching second. In single-event mode the alarm disarms after it fires, and it stays disarmed until one of its own registers is written again.

Top module: `cal_alarm_cmp`

## Requirements
- R1: While `rst_n` is low and right after reset, both flags and `irq` are 0. All alarm bytes are cleared, so with no writes the block never fires. The mode bits reset to 0 (single event), the interrupt enables reset to 2'b11, and both alarms start armed.
- R2: The write map places alarm n (n = `wr_addr[3]`) fields at slots 0..5 of `wr_addr[2:0]`: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week. When every field whose byte has bit 7 = 1 equals the current input in bits 6:0, and `tick_1hz` is high, `alarm_flag[n]` reads 1 one clock edge later.
- R3: A field whose bit 7 is 0 is ignored, whatever the current value of that input.
- R4: An alarm with bit 7 clear in all six bytes never sets its flag.
- R5: A matching time without `tick_1hz` high does not set a flag.
- R6: With mode bit 0 = 0 at slot 6 of that alarm, the alarm disarms after it fires. No further event occurs until any byte at slots 0..6 of that alarm is written, which re-arms it.
- R7: With mode bit 0 = 1, the alarm fires again on every matching tick.
- R8: A flag stays set until a write to address 15 with a 1 in bit n clears flag n. A 0 in that bit leaves the flag unchanged.
- R9: `irq` is the OR of the flags whose enable bit is 1 in the byte written at address 7 (bit n enables alarm n).
- R10: If a tick that fires alarm n falls in the same cycle as a clear of flag n, the flag ends up set.
- R11: The two alarms are independent: one alarm's settings and events never change the other's flag.
- R12: The hours comparison covers bit 6, the 12/24-hour format bit, so a difference in that bit alone is a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz | input | 1 | One-cycle pulse per second, time inputs already updated |
| tm_sec | input | 7 | Current seconds, BCD |
| tm_min | input | 7 | Current minutes, BCD |
| tm_hour | input | 7 | Current hours, BCD, bit 6 = 24-hour format |
| tm_date | input | 7 | Current day of month, BCD |
| tm_month | input | 7 | Current month, BCD |
| tm_dow | input | 7 | Current day of week |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| alarm_flag | output | 2 | Sticky per-alarm event flags |
| irq | output | 1 | Combined interrupt |

## Verification
Two events can land in the same cycle: a tick whose match sets a flag, and a software write that clears that flag. The bench drives both at one falling edge. It drives the clear once while the flag is already set and once while it is clear, and expects the flag to read 1 afterwards in both cases. A re-arming write in the same cycle as a firing tick is the second overlap. The checker covers it by exempting cycles with a write from its disarm property.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int NUM_ALARMS = 2;
    localparam int NUM_FIELDS = 6;
    localparam int FIELD_W    = 7;
    localparam int BYTE_W     = 8;
    localparam int EN_BIT     = BYTE_W - 1;
    localparam int SLOT_BITS  = 3;
    localparam int SEL_W      = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1;
    localparam int ADDR_W     = SEL_W + SLOT_BITS;

    localparam logic [SLOT_BITS-1:0] SLOT_MODE = 3'd6;
    localparam logic [SLOT_BITS-1:0] SLOT_AUX  = 3'd7;

    typedef logic [BYTE_W-1:0]  abyte_t;
    typedef logic [FIELD_W-1:0] bcd_t;

    typedef struct packed {
        abyte_t [NUM_FIELDS-1:0] fld;
        logic                    rpt;
    } alarm_cfg_t;
endpackage

// File: rtl/alarm_regfile.sv
module alarm_regfile
    import alarm_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [BYTE_W-1:0]            wr_data,
    output alarm_cfg_t [NUM_ALARMS-1:0]  cfg,
    output logic [NUM_ALARMS-1:0]        ien,
    output logic [NUM_ALARMS-1:0]        rearm,
    output logic [NUM_ALARMS-1:0]        clr
);
    typedef struct packed {
        alarm_cfg_t [NUM_ALARMS-1:0] cfg;
        logic [NUM_ALARMS-1:0]       ien;
    } rf_state_t;

    rf_state_t st_d, st_q;

    logic [SEL_W-1:0]     sel;
    logic [SLOT_BITS-1:0] slot;

    assign sel  = wr_addr[ADDR_W-1 -: SEL_W];
    assign slot = wr_addr[SLOT_BITS-1:0];

    always_comb begin
        st_d  = st_q;
        rearm = '0;
        clr   = '0;
        if (wr_en) begin
            for (int a = 0; a < NUM_ALARMS; a++) begin
                if (sel == SEL_W'(a)) begin
                    for (int f = 0; f < NUM_FIELDS; f++) begin
                        if (slot == SLOT_BITS'(f)) begin
                            st_d.cfg[a].fld[f] = wr_data;
                            rearm[a]           = 1'b1;
                        end
                    end
                    if (slot == SLOT_MODE) begin
                        st_d.cfg[a].rpt = wr_data[0];
                        rearm[a]        = 1'b1;
                    end
                end
            end
            if (slot == SLOT_AUX) begin
                if (sel == '0)
                    st_d.ien = wr_data[NUM_ALARMS-1:0];
                else if (sel == SEL_W'(NUM_ALARMS-1))
                    clr = wr_data[NUM_ALARMS-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ien <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.cfg;
    assign ien = st_q.ien;
endmodule

// File: rtl/alarm_match.sv
module alarm_match
    import alarm_pkg::*;
(
    input  abyte_t [NUM_FIELDS-1:0] fld,
    input  bcd_t   [NUM_FIELDS-1:0] now,
    output logic                    hit,
    output logic                    any_en
);
    logic [NUM_FIELDS-1:0] en;
    logic [NUM_FIELDS-1:0] ok;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        assign en[f] = fld[f][EN_BIT];
        assign ok[f] = !en[f] || (fld[f][FIELD_W-1:0] == now[f]);
    end

    assign hit    = &ok;
    assign any_en = |en;
endmodule

// File: rtl/alarm_channel.sv
module alarm_channel (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    input  logic any_en,
    input  logic rpt,
    input  logic rearm,
    input  logic clr,
    output logic flag,
    output logic armed
);
    typedef struct packed {
        logic flag;
        logic armed;
    } ch_state_t;

    ch_state_t ch_d, ch_q;
    logic fire;

    always_comb begin
        ch_d = ch_q;
        fire = tick && ch_q.armed && any_en && hit;
        ch_d.flag = fire || (ch_q.flag && !clr);
        if (rearm)
            ch_d.armed = 1'b1;
        else if (fire && !rpt)
            ch_d.armed = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q.flag  <= 1'b0;
            ch_q.armed <= 1'b1;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign flag  = ch_q.flag;
    assign armed = ch_q.armed;
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
    import alarm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_1hz,
    input  logic [FIELD_W-1:0]    tm_sec,
    input  logic [FIELD_W-1:0]    tm_min,
    input  logic [FIELD_W-1:0]    tm_hour,
    input  logic [FIELD_W-1:0]    tm_date,
    input  logic [FIELD_W-1:0]    tm_month,
    input  logic [FIELD_W-1:0]    tm_dow,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [BYTE_W-1:0]     wr_data,
    output logic [NUM_ALARMS-1:0] alarm_flag,
    output logic                  irq
);
    bcd_t [NUM_FIELDS-1:0]       now;
    alarm_cfg_t [NUM_ALARMS-1:0] cfg;
    logic [NUM_ALARMS-1:0]       ien;
    logic [NUM_ALARMS-1:0]       rearm;
    logic [NUM_ALARMS-1:0]       clr;
    logic [NUM_ALARMS-1:0]       hit;
    logic [NUM_ALARMS-1:0]       any_en;
    logic [NUM_ALARMS-1:0]       armed;
    logic [NUM_ALARMS-1:0]       rpt_mode;

    assign now = {tm_dow, tm_month, tm_date, tm_hour, tm_min, tm_sec};

    alarm_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .ien     (ien),
        .rearm   (rearm),
        .clr     (clr)
    );

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
        assign rpt_mode[a] = cfg[a].rpt;

        alarm_match u_match (
            .fld    (cfg[a].fld),
            .now    (now),
            .hit    (hit[a]),
            .any_en (any_en[a])
        );

        alarm_channel u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick_1hz),
            .hit    (hit[a]),
            .any_en (any_en[a]),
            .rpt    (rpt_mode[a]),
            .rearm  (rearm[a]),
            .clr    (clr[a]),
            .flag   (alarm_flag[a]),
            .armed  (armed[a])
        );
    end

    assign irq = |(alarm_flag & ien);
endmodule

// File: rtl/cal_alarm_cmp_checker.sv
module cal_alarm_cmp_checker
    import alarm_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick_1hz,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [BYTE_W-1:0]     wr_data,
    input logic [NUM_ALARMS-1:0] alarm_flag,
    input logic                  irq,
    input logic [NUM_ALARMS-1:0] armed,
    input logic [NUM_ALARMS-1:0] any_en,
    input logic [NUM_ALARMS-1:0] rpt_mode
);
    localparam logic [ADDR_W-1:0] CLR_ADDR = {SEL_W'(NUM_ALARMS-1), SLOT_AUX};

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> alarm_flag == '0);

    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> alarm_flag != '0);

    for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_chk
        assert_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(alarm_flag[a]) |-> $past(tick_1hz));

        assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            alarm_flag[a] && !(wr_en && wr_addr == CLR_ADDR && wr_data[a])
            |=> alarm_flag[a]);

        assert_no_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !alarm_flag[a] && !any_en[a] |=> !alarm_flag[a]);

        assert_single_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(alarm_flag[a]) && !$past(rpt_mode[a]) && !$past(wr_en)
            |-> !armed[a]);
    end
endmodule

bind cal_alarm_cmp cal_alarm_cmp_checker u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_1hz   (tick_1hz),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .alarm_flag (alarm_flag),
    .irq        (irq),
    .armed      (armed),
    .any_en     (any_en),
    .rpt_mode   (rpt_mode)
);

// File: tb/tb_cal_alarm_cmp.sv
module tb_cal_alarm_cmp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic [6:0] tm_sec = '0, tm_min = '0, tm_hour = '0;
    logic [6:0] tm_date = '0, tm_month = '0, tm_dow = '0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] alarm_flag;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cal_alarm_cmp dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour),
        .tm_date(tm_date), .tm_month(tm_month), .tm_dow(tm_dow),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .alarm_flag(alarm_flag), .irq(irq)
    );

    // Fields: sec, min, hour, date, month, dow, expected alarm 0 hit.
    // Alarm 0 compares seconds = 30 and hours = 52 (24-hour bit set, 12).
    localparam logic [42:0] VEC [0:7] = '{
        {7'h30, 7'h00, 7'h52, 7'h01, 7'h01, 7'h01, 1'b1},
        {7'h30, 7'h59, 7'h52, 7'h15, 7'h01, 7'h02, 1'b1},
        {7'h31, 7'h00, 7'h52, 7'h01, 7'h01, 7'h01, 1'b0},
        {7'h30, 7'h00, 7'h12, 7'h01, 7'h01, 7'h01, 1'b0},
        {7'h30, 7'h00, 7'h53, 7'h01, 7'h01, 7'h01, 1'b0},
        {7'h30, 7'h27, 7'h52, 7'h28, 7'h12, 7'h06, 1'b1},
        {7'h00, 7'h00, 7'h00, 7'h01, 7'h01, 7'h01, 1'b0},
        {7'h30, 7'h45, 7'h52, 7'h31, 7'h07, 7'h00, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic set_time(input logic [6:0] s, mi, h, dt, mo, w);
        tm_sec = s; tm_min = mi; tm_hour = h;
        tm_date = dt; tm_month = mo; tm_dow = w;
    endtask

    task automatic tick();
        tick_1hz = 1'b1;
        cyc();
        tick_1hz = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 flags in reset", {6'b0, alarm_flag}, 8'h00);
        chk("R1 irq in reset", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        cyc();
        chk("R1 flags after reset", {6'b0, alarm_flag}, 8'h00);
        set_time(7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00);
        tick();
        chk("R1 cleared bytes never fire", {6'b0, alarm_flag}, 8'h00);

        // Alarm 0: seconds and hours enabled, repeat mode.
        wr(4'd0, 8'hB0);
        wr(4'd2, 8'hD2);
        wr(4'd6, 8'h01);
        for (int i = 0; i < 8; i++) begin
            logic [42:0] v;
            v = VEC[i];
            wr(4'd15, 8'h03);
            set_time(v[42:36], v[35:29], v[28:22], v[21:15], v[14:8], v[7:1]);
            tick();
            chk("R2 R3 R7 R12 alarm0 vector", {6'b0, alarm_flag}, {7'b0, v[0]});
            chk("R9 irq vector", {7'b0, irq}, {7'b0, v[0]});
        end

        // Alarm 1 single-event on seconds = 05.
        wr(4'd15, 8'h03);
        wr(4'd8, 8'h85);
        wr(4'd14, 8'h00);
        set_time(7'h05, 7'h00, 7'h52, 7'h01, 7'h01, 7'h01);
        tick();
        chk("R6 R11 alarm1 fires alone", {6'b0, alarm_flag}, 8'h02);
        wr(4'd15, 8'h01);
        chk("R8 clear other bit keeps flag", {6'b0, alarm_flag}, 8'h02);
        wr(4'd7, 8'h01);
        chk("R9 masked alarm1 no irq", {7'b0, irq}, 8'h00);
        wr(4'd7, 8'h03);
        chk("R9 enabled alarm1 irq", {7'b0, irq}, 8'h01);
        wr(4'd15, 8'h02);
        chk("R8 clear alarm1", {6'b0, alarm_flag}, 8'h00);
        tick();
        chk("R6 disarmed after event", {6'b0, alarm_flag}, 8'h00);
        wr(4'd14, 8'h00);
        tick();
        chk("R6 rearmed by rewrite", {6'b0, alarm_flag}, 8'h02);
        wr(4'd15, 8'h03);

        // No tick: matching time held for several cycles.
        set_time(7'h30, 7'h00, 7'h52, 7'h01, 7'h01, 7'h01);
        repeat (3) cyc();
        chk("R5 no tick no event", {6'b0, alarm_flag}, 8'h00);

        // Same-cycle fire and clear.
        tick_1hz = 1'b1; wr_en = 1'b1; wr_addr = 4'd15; wr_data = 8'h01;
        cyc();
        tick_1hz = 1'b0; wr_en = 1'b0;
        chk("R10 set wins from clear state", {6'b0, alarm_flag}, 8'h01);
        tick_1hz = 1'b1; wr_en = 1'b1; wr_addr = 4'd15; wr_data = 8'h01;
        cyc();
        tick_1hz = 1'b0; wr_en = 1'b0;
        chk("R10 set wins from set state", {6'b0, alarm_flag}, 8'h01);
        wr(4'd15, 8'h01);
        chk("R8 plain clear", {6'b0, alarm_flag}, 8'h00);

        // Alarm 0 disabled completely.
        wr(4'd0, 8'h30);
        wr(4'd2, 8'h52);
        tick();
        chk("R4 no enabled fields", {6'b0, alarm_flag}, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule